// File: doc/BRIEF.md
# Up/Down Modulo Timer Counter

This block is the central count engine of a timer. It holds a count register whose limit comes from a modulo value. Counting is paced by one of three external clock-enable sources, and a power-of-two prescaler divides that enable further. A two-bit selector picks the source. The value zero on that selector switches the timer off without losing any state.

A single mode input chooses how the counter moves. With the mode input low, the counter only counts up and wraps at its limit, which suits general timing. With the mode input high, the counter climbs to the limit and then descends to zero, which gives the triangle wave that center-aligned PWM channels compare against.

An overflow pulse marks the end of each period. A clear strobe, raised whenever software writes the count, restarts both the counter and the prescaler.

Top module: `updown_mod_timer`

## Requirements
- R1: After reset, `count` is 0, `count_down` is 0 and `overflow` is 0. The prescaler phase is also 0.
- R2: While `clk_sel` is 0, the count, the direction and the prescaler phase keep their values, whatever the enable inputs do. When a source is selected again, counting resumes from the held prescaler phase.
- R3: A `clk_sel` value of 1, 2 or 3 selects `src_en[0]`, `src_en[1]` or `src_en[2]` respectively. The two enables that are not selected have no effect.
- R4: The count takes one step for every 2^`ps_sel` cycles in which the selected enable is high. With `ps_sel` equal to 0, every such cycle produces a step.
- R5: With `center_mode` low, each step adds one until the count is at or above the limit. The step after that loads 0 and pulses `overflow`. `count_down` is 0 in this mode.
- R6: A `modulo` value of 0 sets the limit to the all-ones value 0xFFFF. In up mode the counter then runs through the whole range.
- R7: With `center_mode` high, the counter rises by one per step. `count_down` goes high on the step that brings the count to the limit. After that, each step subtracts one.
- R8: In center mode, the step that brings a descending count to 0 pulses `overflow` and returns `count_down` to 0. The next step counts up again.
- R9: A high `cnt_clear` sets the count, the prescaler phase, `count_down` and `overflow` to 0 on the next edge. It takes priority over any enable.
- R10: `overflow` is high for one cycle only, and only while `count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_sel | input | 2 | Count source select; 0 means off |
| ps_sel | input | 3 | Prescale exponent; divide by 2^ps_sel |
| center_mode | input | 1 | 1 = up/down counting, 0 = up counting |
| modulo | input | 16 | Count limit; 0 means 0xFFFF |
| src_en | input | 3 | Clock-enable pulses of the three sources |
| cnt_clear | input | 1 | Counter write strobe; clears count and prescaler |
| count | output | 16 | Current count |
| count_down | output | 1 | High while the counter is descending |
| overflow | output | 1 | One-cycle end-of-period pulse |

## Verification
The bench builds the block with its default parameters: a 16-bit counter and a 3-bit prescale exponent. The 16-bit width lets one free-running pass with `modulo` at 0 reach the 0xFFFF wrap within the run. The 3-bit exponent is exercised at several divide ratios, together with enables that fire every cycle, every third cycle and in a pseudo-random pattern.

Short limits in center mode bring both reversal points close together, including a limit of 1. The bench also switches modes and the off code while the counter is descending.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    localparam logic [1:0] SEL_OFF = 2'd0;

endpackage

// File: rtl/tmr_src_sel.sv
module tmr_src_sel #(
    parameter int SEL_W = 2,
    localparam int N_SRC = (1 << SEL_W) - 1
) (
    input  logic [SEL_W-1:0] clk_sel,
    input  logic [N_SRC-1:0] src_en,
    output logic             tick
);
    logic [N_SRC-1:0] hit;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign hit[i] = (clk_sel == SEL_W'(i + 1)) && src_en[i];
    end

    assign tick = |hit;
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PS_W = 3,
    localparam int PC_W = (1 << PS_W) - 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            clr,
    input  logic [PS_W-1:0] ps_sel,
    output logic            adv
);
    typedef struct packed {
        logic [PC_W-1:0] phase;
    } ps_t;

    ps_t             s_d, s_q;
    logic [PC_W-1:0] lim;

    always_comb begin
        lim = PC_W'((1 << ps_sel) - 1);
        adv = 1'b0;
        s_d = s_q;
        if (clr) begin
            s_d.phase = '0;
        end else if (tick) begin
            if (s_q.phase >= lim) begin
                s_d.phase = '0;
                adv       = 1'b1;
            end else begin
                s_d.phase = s_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2: without a tick the prescale phase holds its value
    assert_ps_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(s_q.phase));
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             clr,
    input  logic             center,
    input  logic [CNT_W-1:0] modulo,
    output logic [CNT_W-1:0] count,
    output logic             count_down,
    output logic             overflow
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        dir_e             dn;
        logic             ovf;
    } core_t;

    core_t            s_d, s_q;
    logic [CNT_W-1:0] top;
    logic [CNT_W-1:0] step_nxt;
    logic             go_down;

    always_comb begin
        top      = (modulo == '0) ? '1 : modulo;
        go_down  = (s_q.dn == DIR_DOWN) ? (s_q.cnt != '0) : (s_q.cnt >= top);
        step_nxt = go_down ? (s_q.cnt - 1'b1) : (s_q.cnt + 1'b1);
        s_d      = s_q;
        s_d.ovf  = 1'b0;
        if (clr) begin
            s_d = '0;
        end else begin
            if (!center) s_d.dn = DIR_UP;
            if (adv) begin
                if (!center) begin
                    if (s_q.cnt >= top) begin
                        s_d.cnt = '0;
                        s_d.ovf = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end else begin
                    s_d.cnt = step_nxt;
                    if (go_down) begin
                        s_d.dn  = (step_nxt != '0) ? DIR_DOWN : DIR_UP;
                        s_d.ovf = (step_nxt == '0);
                    end else begin
                        s_d.dn  = (step_nxt >= top) ? DIR_DOWN : DIR_UP;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count      = s_q.cnt;
    assign count_down = (s_q.dn == DIR_DOWN);
    assign overflow   = s_q.ovf;

    // R5: a step at or above the limit in up mode wraps to zero with overflow
    assert_up_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && !center && (s_q.cnt >= top)) |=> ((count == '0) && overflow));

    // R7: a descending step in center mode subtracts one
    assert_down_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && center && count_down && (count != '0))
        |=> (count == $past(count) - 1'b1));

    // R10: overflow only ever accompanies a zero count
    assert_ovf_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (count == '0));
endmodule

// File: rtl/updown_mod_timer.sv
module updown_mod_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PS_W  = 3,
    parameter int SEL_W = 2,
    localparam int N_SRC = (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] clk_sel,
    input  logic [PS_W-1:0]  ps_sel,
    input  logic             center_mode,
    input  logic [CNT_W-1:0] modulo,
    input  logic [N_SRC-1:0] src_en,
    input  logic             cnt_clear,
    output logic [CNT_W-1:0] count,
    output logic             count_down,
    output logic             overflow
);
    logic tick;
    logic adv;

    tmr_src_sel #(.SEL_W(SEL_W)) u_sel (
        .clk_sel (clk_sel),
        .src_en  (src_en),
        .tick    (tick)
    );

    tmr_prescaler #(.PS_W(PS_W)) u_ps (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .clr    (cnt_clear),
        .ps_sel (ps_sel),
        .adv    (adv)
    );

    tmr_count_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (adv),
        .clr        (cnt_clear),
        .center     (center_mode),
        .modulo     (modulo),
        .count      (count),
        .count_down (count_down),
        .overflow   (overflow)
    );

    // R2: the off code freezes the count
    assert_off_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((clk_sel == SEL_OFF) && !cnt_clear) |=> $stable(count));

    // R9: clear strobe zeroes the count and direction
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clear |=> ((count == '0) && !count_down && !overflow));

    // R5: up mode never reports descending
    assert_up_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !center_mode |=> !count_down);

    // R10: overflow lasts one cycle
    assert_ovf_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> !overflow);
endmodule

// File: tb/tb_updown_mod_timer.sv
module tb_updown_mod_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  clk_sel = 2'd0;
    logic [2:0]  ps_sel = 3'd0;
    logic        center_mode = 1'b0;
    logic [15:0] modulo = 16'd0;
    logic [2:0]  src_en = 3'd0;
    logic        cnt_clear = 1'b0;
    logic [15:0] count;
    logic        count_down;
    logic        overflow;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    logic [7:0] lf = 8'hA5;
    string cur_req = "R1";
    bit done = 0;

    int m_cnt = 0, m_ps = 0;
    bit m_dn = 0, m_ovf = 0;
    int ovf_seen = 0;

    always #2 clk = ~clk;

    updown_mod_timer dut (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ps_sel(ps_sel),
        .center_mode(center_mode), .modulo(modulo), .src_en(src_en),
        .cnt_clear(cnt_clear), .count(count), .count_down(count_down),
        .overflow(overflow)
    );

    // behavioural reference, evaluated once per edge from stable inputs
    always @(posedge clk) begin
        int lim;
        bit tk;
        if (!rst_n) begin
            m_cnt = 0; m_ps = 0; m_dn = 0; m_ovf = 0;
        end else if (cnt_clear) begin
            m_cnt = 0; m_ps = 0; m_dn = 0; m_ovf = 0;
        end else begin
            m_ovf = 0;
            lim = (modulo == 0) ? 65535 : int'(modulo);
            tk = (clk_sel != 0) && src_en[clk_sel - 1];
            if (!center_mode) m_dn = 0;
            if (tk) begin
                m_ps++;
                if (m_ps >= (1 << ps_sel)) begin
                    m_ps = 0;
                    if (!center_mode) begin
                        if (m_cnt >= lim) begin m_cnt = 0; m_ovf = 1; end
                        else m_cnt++;
                    end else if (m_dn && m_cnt > 0) begin
                        m_cnt--;
                        if (m_cnt == 0) begin m_dn = 0; m_ovf = 1; end
                    end else if (m_cnt >= lim) begin
                        m_cnt--;
                        m_dn = 1;
                        if (m_cnt == 0) begin m_dn = 0; m_ovf = 1; end
                    end else begin
                        m_cnt++;
                        if (m_cnt >= lim) m_dn = 1;
                    end
                end
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cyc++;
            chk({cur_req, " count"}, count, m_cnt);
            chk({cur_req, " dir"}, count_down, m_dn);
            chk({cur_req, " ovf"}, overflow, m_ovf);
            if (overflow) ovf_seen++;
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            src_en = {lf[0], (cyc % 3 == 0), 1'b1};
        end
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 count", count, 0);
        chk("R1 dir", count_down, 0);
        chk("R1 ovf", overflow, 0);

        cur_req = "R5"; clk_sel = 2'd1; ps_sel = 3'd0; modulo = 16'd5;
        run(20);
        cur_req = "R4"; ps_sel = 3'd2; run(40);
        ps_sel = 3'd7; run(300);
        ps_sel = 3'd1;
        cur_req = "R3"; clk_sel = 2'd2; run(40);
        clk_sel = 2'd3; run(60);

        // R2: off code holds everything with enables toggling
        cur_req = "R2"; clk_sel = 2'd1; ps_sel = 3'd2; run(5);
        clk_sel = 2'd0; held = count; run(20);
        chk("R2 held count", count, held);
        clk_sel = 2'd1; run(12);

        cur_req = "R7"; center_mode = 1'b1; modulo = 16'd4; ps_sel = 3'd0;
        cnt_clear = 1'b1; run(1); cnt_clear = 1'b0;
        run(40);
        cur_req = "R8"; modulo = 16'd1; run(12);
        modulo = 16'd3; ps_sel = 3'd1; clk_sel = 2'd3; run(60);
        // direction survives the off code in center mode
        clk_sel = 2'd1; ps_sel = 3'd0; modulo = 16'd6; run(9);
        cur_req = "R2"; clk_sel = 2'd0; run(6);
        cur_req = "R7"; clk_sel = 2'd1; run(10);
        // lowered limit while above it
        modulo = 16'd2; run(12);
        // mode change while descending
        modulo = 16'd8; run(12);
        cur_req = "R5"; center_mode = 1'b0; run(20);

        // R9: clear wins over an active enable
        cur_req = "R9"; ps_sel = 3'd2; run(7);
        cnt_clear = 1'b1; run(1);
        chk("R9 cleared", count, 0);
        cnt_clear = 1'b0; run(10);
        center_mode = 1'b1; run(8);
        cnt_clear = 1'b1; run(1);
        chk("R9 dir cleared", count_down, 0);
        cnt_clear = 1'b0;

        // R6: free run through the full range
        cur_req = "R6"; center_mode = 1'b0; modulo = 16'd0; ps_sel = 3'd0; clk_sel = 2'd1;
        ovf_seen = 0;
        run(65540);
        chk("R6 one wrap", ovf_seen, 1);
        cur_req = "R10"; modulo = 16'd1; ovf_seen = 0; run(20);
        chk("R10 pulse count", ovf_seen, 10);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule